// File: doc/BRIEF.md
# Selectable-Ratio Third-Order Sinc Decimator

This block turns a one-bit delta-sigma modulator stream into 16-bit two's complement samples. It uses a three-stage cascaded integrator-comb filter with the response ((1 - z^-N)/(1 - z^-1))^3. Each input bit is read as +1 (bit high) or -1 (bit low). The block takes one bit every eighth master clock and shows which clock that is on `bit_strobe`. The result is scaled so that a stream of all ones gives positive full scale and a stream of all zeros gives negative full scale. Values that would overflow are clamped.

The ratio N is 256 when `rate_sel` is low and 128 when it is high. An output word therefore appears every 2048 or every 1024 master clocks. The select is captured only while reset is asserted. A change during operation has no effect until the next reset.

A small fill-tracking state machine runs next to the datapath. Its states are:
- `ST_PRIME`: lets the first two bits enter the integrators. It moves to `ST_FILL0` on the second bit strobe.
- `ST_FILL0`: moves to `ST_FILL1` on the first decimation tick.
- `ST_FILL1`: moves to `ST_LIVE` on the next decimation tick.
- `ST_LIVE`: holds until reset.

A word emitted from `ST_LIVE` is marked settled. The two words before it, which are still filling the comb delay lines, are not.

Top module: `cic_sinc3_decim`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next cycle shows `out_valid`=0, `out_settled`=0 and `out_code`=0x0000.
- R2: `bit_strobe` is high for one clock in every 8. The first pulse comes in the 8th clock after reset is released. `mod_bit` is read on that clock's rising edge, with 1 meaning +1 and 0 meaning -1.
- R3: `out_valid` pulses for one clock. Consecutive pulses are 2048 clocks apart when the captured select is 0 (N=256) and 1024 clocks apart when it is 1 (N=128).
- R4: `rate_sel` is sampled only while `rst_n` is low. Toggling it during operation leaves the pulse spacing unchanged.
- R5: For a periodic stream with ones density d and a period that divides N, a settled word equals floor((2d-1)·N³ / 2^(3·log2(N)-15)). For example, d=1/4 gives 0xC000 (-16384) and d=7/8 gives 0x6000 (24576).
- R6: The output saturates and never wraps. All ones gives 0x7FFF (32767) and all zeros gives 0x8000 (-32768), for both ratios.
- R7: An alternating 0/1 stream gives a settled code of 0x0000.
- R8: The first two words after reset have `out_settled`=0. The third word and every later one have `out_settled`=1. `out_settled` is never high without `out_valid`.
- R9: `out_code` holds its value between `out_valid` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset; `rate_sel` is captured while it is low |
| rate_sel | input | 1 | Ratio select: 0 gives N=256, 1 gives N=128 |
| mod_bit | input | 1 | Modulator bit, read when `bit_strobe` is high |
| bit_strobe | output | 1 | Marks the clock on which `mod_bit` is read (once every 8 clocks) |
| out_valid | output | 1 | One-clock pulse when a new word is on `out_code` |
| out_settled | output | 1 | High together with `out_valid` once the filter window is full |
| out_code | output | 16 | Two's complement output word |

## Verification
Every decimation tick lands on a bit strobe. On that edge the integrators take in the last bit of the block, and the comb stages sample the integrator result and step the fill state machine. A slip of one cycle in either path changes the code of a window or moves the first settled word.

The bench drives periodic patterns whose first and last bits within each window differ (one-in-four, seven-in-eight, three-in-eight). It then requires the third word after reset to carry both the settled flag and the exact code that the density formula predicts. The bench compares the spacing of the output pulses against 2048 or 1024 clocks, independently of the codes.

// File: rtl/cic_pkg.sv
package cic_pkg;

    // Fill-tracking states for the decimator control
    typedef enum logic [1:0] {
        ST_PRIME = 2'd0,
        ST_FILL0 = 2'd1,
        ST_FILL1 = 2'd2,
        ST_LIVE  = 2'd3
    } fill_state_t;

endpackage

// File: rtl/cic_rate_gen.sv
module cic_rate_gen #(
    parameter int DIV_LOG  = 3,
    parameter int LOG_N_LO = 8,
    parameter int LOG_N_HI = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fast,
    input  logic run,
    output logic bit_stb,
    output logic dec_tick
);
    localparam int LW = LOG_N_LO;
    localparam logic [LW-1:0] LAST_LO = LW'((1 << LOG_N_LO) - 1);
    localparam logic [LW-1:0] LAST_HI = LW'((1 << LOG_N_HI) - 1);

    logic [DIV_LOG-1:0] ph;
    logic [LW-1:0]      dcnt;
    logic [LW-1:0]      last;

    assign bit_stb  = &ph;
    assign last     = fast ? LAST_HI : LAST_LO;
    assign dec_tick = bit_stb && run && (dcnt == last);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph <= '0;
        end else begin
            ph <= ph + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dcnt <= '0;
        end else if (bit_stb && run) begin
            dcnt <= (dcnt == last) ? '0 : dcnt + 1'b1;
        end
    end
endmodule

// File: rtl/cic_integrators.sv
module cic_integrators #(
    parameter int ORDER = 3,
    parameter int IW    = 26
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 bit_in,
    output logic signed [IW-1:0] acc_out
);
    logic signed [IW-1:0] acc [ORDER];
    logic signed [IW-1:0] x_in;

    assign x_in    = bit_in ? IW'(1) : {IW{1'b1}};
    assign acc_out = acc[ORDER-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < ORDER; k++) acc[k] <= '0;
        end else if (en) begin
            acc[0] <= acc[0] + x_in;
            for (int k = 1; k < ORDER; k++) acc[k] <= acc[k] + acc[k-1];
        end
    end
endmodule

// File: rtl/cic_combs.sv
module cic_combs #(
    parameter int ORDER = 3,
    parameter int IW    = 26
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic signed [IW-1:0] din,
    output logic signed [IW-1:0] dout
);
    logic signed [IW-1:0] dly [ORDER];
    logic signed [IW-1:0] stg [ORDER+1];

    always_comb begin
        stg[0] = din;
        for (int k = 0; k < ORDER; k++) stg[k+1] = stg[k] - dly[k];
    end

    assign dout = stg[ORDER];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < ORDER; k++) dly[k] <= '0;
        end else if (tick) begin
            for (int k = 0; k < ORDER; k++) dly[k] <= stg[k];
        end
    end
endmodule

// File: rtl/cic_sinc3_decim.sv
module cic_sinc3_decim
    import cic_pkg::*;
#(
    parameter int LOG_N_LO = 8,
    parameter int LOG_N_HI = 7,
    parameter int DIV_LOG  = 3,
    parameter int ORDER    = 3,
    parameter int OUT_W    = 16,
    parameter int PRIME    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rate_sel,
    input  logic             mod_bit,
    output logic             bit_strobe,
    output logic             out_valid,
    output logic             out_settled,
    output logic [OUT_W-1:0] out_code
);
    localparam int IW    = ORDER * LOG_N_LO + 2;
    localparam int SH_LO = ORDER * LOG_N_LO - (OUT_W - 1);
    localparam int SH_HI = ORDER * LOG_N_HI - (OUT_W - 1);
    localparam int PW    = (PRIME > 1) ? $clog2(PRIME) : 1;
    localparam logic signed [IW-1:0] MAXV = {{(IW-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [IW-1:0] MINV = ~MAXV;

    fill_state_t          state, state_nx;
    logic                 fast_q;
    logic [PW-1:0]        pcnt;
    logic                 prime_done;
    logic                 dec_tick;
    logic                 run;
    logic signed [IW-1:0] integ_q;
    logic signed [IW-1:0] raw;
    logic signed [IW-1:0] shifted;
    logic [OUT_W-1:0]     sat_code;

    // Ratio select is captured only while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) fast_q <= rate_sel;
    end

    assign run = (state != ST_PRIME);

    cic_rate_gen #(
        .DIV_LOG (DIV_LOG),
        .LOG_N_LO(LOG_N_LO),
        .LOG_N_HI(LOG_N_HI)
    ) u_rate (
        .clk     (clk),
        .rst_n   (rst_n),
        .fast    (fast_q),
        .run     (run),
        .bit_stb (bit_strobe),
        .dec_tick(dec_tick)
    );

    cic_integrators #(.ORDER(ORDER), .IW(IW)) u_integ (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (bit_strobe),
        .bit_in (mod_bit),
        .acc_out(integ_q)
    );

    cic_combs #(.ORDER(ORDER), .IW(IW)) u_comb (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (dec_tick),
        .din  (integ_q),
        .dout (raw)
    );

    // Scale to the output width and clamp
    always_comb begin
        shifted = raw >>> (fast_q ? SH_HI : SH_LO);
        if (shifted > MAXV) begin
            sat_code = {1'b0, {(OUT_W-1){1'b1}}};
        end else if (shifted < MINV) begin
            sat_code = {1'b1, {(OUT_W-1){1'b0}}};
        end else begin
            sat_code = shifted[OUT_W-1:0];
        end
    end

    // Priming counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt <= '0;
        end else if (state == ST_PRIME && bit_strobe) begin
            pcnt <= pcnt + 1'b1;
        end
    end

    assign prime_done = bit_strobe && (pcnt == PW'(PRIME - 1));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_PRIME;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_PRIME: if (prime_done) state_nx = ST_FILL0;
            ST_FILL0: if (dec_tick)   state_nx = ST_FILL1;
            ST_FILL1: if (dec_tick)   state_nx = ST_LIVE;
            ST_LIVE:                  state_nx = ST_LIVE;
        endcase
    end

    // Output process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_settled <= 1'b0;
            out_code    <= '0;
        end else begin
            out_valid <= dec_tick;
            if (dec_tick) begin
                out_code    <= sat_code;
                out_settled <= (state == ST_LIVE);
            end else begin
                out_settled <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/cic_sinc3_checks.sv
module cic_sinc3_checks #(
    parameter int LOG_N_LO = 8,
    parameter int LOG_N_HI = 7,
    parameter int DIV_LOG  = 3,
    parameter int OUT_W    = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fast_q,
    input logic             bit_strobe,
    input logic             out_valid,
    input logic             out_settled,
    input logic [OUT_W-1:0] out_code
);
    localparam int GW = DIV_LOG + LOG_N_LO + 1;
    localparam logic [GW-1:0] GAP_LO = GW'((1 << (DIV_LOG + LOG_N_LO)) - 1);
    localparam logic [GW-1:0] GAP_HI = GW'((1 << (DIV_LOG + LOG_N_HI)) - 1);
    localparam logic [DIV_LOG:0] SGAP = (DIV_LOG+1)'((1 << DIV_LOG) - 1);

    logic [DIV_LOG:0] sgap;
    logic [GW-1:0]    vgap;
    logic             vseen;
    logic [1:0]       nval;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sgap  <= '0;
            vgap  <= '0;
            vseen <= 1'b0;
            nval  <= '0;
        end else begin
            sgap <= bit_strobe ? '0 : sgap + 1'b1;
            vgap <= out_valid ? '0 : vgap + 1'b1;
            if (out_valid) vseen <= 1'b1;
            if (out_valid && nval != 2'd2) nval <= nval + 1'b1;
        end
    end

    // R1: reset clears the outputs
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_settled && out_code == '0));

    // R2: bit strobe period
    p_strobe_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_strobe |-> sgap == SGAP);

    // R3: output pulse spacing per ratio
    p_valid_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && vseen) |-> vgap == (fast_q ? GAP_HI : GAP_LO));

    p_valid_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R4: captured ratio does not move while running
    p_rate_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(fast_q));

    // R8: settled flag sequence
    p_settled_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_settled |-> out_valid);

    p_settled_third_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_settled == (nval == 2'd2)));

    // R9: code held between strobes
    p_code_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_code));
endmodule

bind cic_sinc3_decim cic_sinc3_checks #(
    .LOG_N_LO(LOG_N_LO),
    .LOG_N_HI(LOG_N_HI),
    .DIV_LOG (DIV_LOG),
    .OUT_W   (OUT_W)
) u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .fast_q     (fast_q),
    .bit_strobe (bit_strobe),
    .out_valid  (out_valid),
    .out_settled(out_settled),
    .out_code   (out_code)
);

// File: tb/test_cic_sinc3_decim.sv
module test_cic_sinc3_decim;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rate_sel = 1'b0;
    logic        mod_bit = 1'b0;
    logic        bit_strobe;
    logic        out_valid;
    logic        out_settled;
    logic [15:0] out_code;

    cic_sinc3_decim i_cic_sinc3_decim (
        .clk        (clk),
        .rst_n      (rst_n),
        .rate_sel   (rate_sel),
        .mod_bit    (mod_bit),
        .bit_strobe (bit_strobe),
        .out_valid  (out_valid),
        .out_settled(out_settled),
        .out_code   (out_code)
    );

    always #2 clk = ~clk;

    typedef struct {
        logic        settled;
        logic        chk;
        logic [15:0] code;
        string       req;
    } exp_t;

    exp_t   sb[$];
    int     checks = 0;
    int     failures = 0;
    longint cyc = 0;
    int     exp_gap = 2048;
    bit     have_last = 0;
    longint last_valid = 0;
    logic [15:0] last_code = '0;
    bit     have_strobe = 0;
    longint last_strobe = 0;
    bit     done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_code(input int ones, input int per, input int logn);
        longint v;
        v = (longint'(2 * ones - per) <<< (3 * logn)) / per;
        v = v >>> (3 * logn - 15);
        if (v > 32767)  v = 32767;
        if (v < -32768) v = -32768;
        return 16'(v);
    endfunction

    // Monitor: pops expected words and checks timing
    always @(negedge clk) begin
        if (!rst_n) begin
            have_last   = 0;
            have_strobe = 0;
        end else begin
            if (bit_strobe) begin
                if (have_strobe)
                    check((cyc - last_strobe) == 8, "R2", "strobe gap", cyc - last_strobe, 8);
                have_strobe = 1;
                last_strobe = cyc;
            end
            if (out_valid) begin
                if (sb.size() == 0) begin
                    check(0, "R3", "unexpected word", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(out_settled == e.settled, "R8", "settled flag", out_settled, e.settled);
                    if (e.chk)
                        check(out_code == e.code, e.req, "code",
                              $signed(out_code), $signed(e.code));
                end
                if (have_last)
                    check((cyc - last_valid) == exp_gap, "R3", "word spacing",
                          cyc - last_valid, exp_gap);
                have_last  = 1;
                last_valid = cyc;
                last_code  = out_code;
            end else if (have_last && cyc == last_valid + 5) begin
                check(out_code == last_code, "R9", "code hold", out_code, last_code);
            end
        end
    end

    // Driver: resets, loads the scoreboard, feeds the pattern
    task automatic run_case(input bit sel, input logic [7:0] pat, input int per,
                            input string req, input bit toggle);
        int ones = 0;
        int idx = 0;
        logic [15:0] code;
        @(negedge clk);
        rst_n    = 1'b0;
        rate_sel = sel;
        repeat (4) @(negedge clk);
        check(!out_valid && !out_settled && out_code == 16'h0000, "R1", "reset state",
              {out_valid, out_settled, out_code}, 0);
        for (int i = 0; i < per; i++) ones += int'(pat[i]);
        code    = exp_code(ones, per, sel ? 7 : 8);
        exp_gap = sel ? 1024 : 2048;
        for (int i = 0; i < 4; i++) begin
            exp_t e;
            e.settled = (i >= 2);
            e.chk     = (i >= 2);
            e.code    = code;
            e.req     = req;
            sb.push_back(e);
        end
        rst_n = 1'b1;
        while (sb.size() > 0) begin
            @(negedge clk);
            if (toggle && idx == 20) rate_sel = ~sel;
            if (bit_strobe) begin
                mod_bit = pat[idx % per];
                idx++;
            end
        end
    endtask

    initial begin
        // R6 with N=128, R3 spacing 1024
        run_case(1'b1, 8'h01, 1, "R6", 1'b0);
        run_case(1'b1, 8'h00, 1, "R6", 1'b0);
        // R5 three-in-eight at N=128: -8192
        run_case(1'b1, 8'h07, 8, "R5", 1'b0);
        // R4: select toggled while running, spacing stays 1024; code 16384
        run_case(1'b1, 8'h07, 4, "R4", 1'b1);
        // N=256 after reset with select low: R6, R7, R5
        run_case(1'b0, 8'h01, 1, "R6", 1'b0);
        run_case(1'b0, 8'h00, 1, "R6", 1'b0);
        run_case(1'b0, 8'h02, 2, "R7", 1'b0);
        run_case(1'b0, 8'h01, 4, "R5", 1'b0);
        run_case(1'b0, 8'h7F, 8, "R5", 1'b0);
        repeat (10) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait (cyc >= 150000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule